// File: doc/BRIEF.md
# Blit Parameter Staging and Launch Queue

This block sits between a host register bus and a 2D blit engine. The host writes a staging copy of every parameter an operation needs: source and destination base addresses, horizontal and vertical clip limits, the stride word, a 64-bit monochrome pattern, pattern and source foreground and background colours, the command word, the rectangle size, and the source and destination coordinates. A launch takes a snapshot of the whole staging set and appends it to a queue of `DEPTH` entries, 16 by default. A launch happens in one of two ways. Writing the command word with its auto bit clear launches. While the auto bit is set, each write to the destination coordinate launches instead.

On the engine side, one snapshot leaves the queue in each cycle where the engine asserts ready and the queue is not empty. The snapshot appears on a wide parallel bus with a one-cycle valid strobe. A busy input stands in for the drawing engine. A status word combines that busy input with the queue fill level. The host reads it to decide whether the engine is idle and how much room the queue has.

Top module: `blit_cmd_queue`

## Requirements
- R1: After reset, every staging word reads zero except the two pattern halves, which read 0xFFFFFFFF. The queue is empty, the status word reads 0x00002F00 and `op_vld` is low.
- R2: A write changes only the byte lanes whose `wr_strb` bit is set; lane i covers data bits 8i+7:8i.
- R3: The 64-bit pattern is written as two halves. Word 9 holds bits 31:0 and word 10 holds bits 63:32. A write to one half leaves the other half unchanged.
- R4: A write to the command word (word 0) whose resulting bit 0 is 0 appends the staging set, including the value just written, to the queue. A write that leaves bit 0 at 1 does not append.
- R5: While the staged command bit 0 (auto mode) is 1, every write to the destination coordinate (word 1) appends the staging set, including the new coordinate. While the bit is 0, such writes append nothing.
- R6: A launch whose command type field (bits 30:27) equals 0xF is a no-op. Nothing is appended, and bit 0 of the staged command word is cleared.
- R7: In a cycle where `eng_ready` is high and the queue is not empty, the oldest entry is removed. In the next cycle `op_vld` is high for one cycle and `op_data` holds that entry. Entries leave in launch order, and `op_vld` stays low when nothing is removed.
- R8: `op_data` is the concatenation, from the MSB down, of: command, destination XY, source XY, size, source base, destination base, stride, clip X, clip Y, pattern[63:0], pattern foreground, pattern background, source foreground and source background.
- R9: Reading word 15 returns the status word. Bits 12:8 are (15 − entries held) modulo 32, which reads 0x1F when the queue is full. Writes to word 15 have no effect.
- R10: Status bit 13 is 1 only when `eng_busy` is low and the queue is empty.
- R11: A launch while the queue holds `DEPTH` entries is dropped and leaves the queue unchanged. It sets status bit 0, which stays set until reset.
- R12: Register reads return the staging values. Changing staging after a launch does not alter the entry already queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte-lane enables |
| rd_addr | input | 4 | Word address of the combinational read |
| rd_data | output | 32 | Read data (staging word or status) |
| eng_ready | input | 1 | Engine accepts one queued entry this cycle |
| eng_busy | input | 1 | Engine is drawing |
| op_vld | output | 1 | `op_data` holds a removed entry |
| op_data | output | 480 | Removed parameter snapshot |

## Verification
The bench sweeps all sixteen byte-strobe patterns. A design that ignored lanes would corrupt neighbouring bytes. It fills the queue one launch at a time and checks the free-slot field at every level, including the wrap to 0x1F at full. An off-by-one count or a saturating field shows up there. The bench then launches once more on a full queue. A design that overwrote the oldest entry, or failed to latch the overflow flag, is caught when the queue is drained and compared entry by entry. The bench also checks the no-op type from both launch paths and checks that an auto-mode launch captures the coordinate written in the same cycle. A design that snapshotted the old value would queue stale coordinates.

// File: rtl/blq_pkg.sv
package blq_pkg;

   localparam int WORD_W   = 32;
   localparam int AUTO_BIT = 0;
   localparam int TYPE_LSB = 27;
   localparam logic [3:0] TYPE_NOP = 4'hF;

   typedef enum logic [3:0] {
      RA_CMD     = 4'd0,
      RA_DXY     = 4'd1,
      RA_SXY     = 4'd2,
      RA_SIZE    = 4'd3,
      RA_SBASE   = 4'd4,
      RA_DBASE   = 4'd5,
      RA_STRIDE  = 4'd6,
      RA_CLIPX   = 4'd7,
      RA_CLIPY   = 4'd8,
      RA_MONO_LO = 4'd9,
      RA_MONO_HI = 4'd10,
      RA_PFG     = 4'd11,
      RA_PBG     = 4'd12,
      RA_SFG     = 4'd13,
      RA_SBG     = 4'd14,
      RA_STAT    = 4'd15
   } reg_addr_e;

   typedef struct packed {
      logic [WORD_W-1:0]   cmd;
      logic [WORD_W-1:0]   dxy;
      logic [WORD_W-1:0]   sxy;
      logic [WORD_W-1:0]   size;
      logic [WORD_W-1:0]   sbase;
      logic [WORD_W-1:0]   dbase;
      logic [WORD_W-1:0]   stride;
      logic [WORD_W-1:0]   clipx;
      logic [WORD_W-1:0]   clipy;
      logic [2*WORD_W-1:0] mono;
      logic [WORD_W-1:0]   pfg;
      logic [WORD_W-1:0]   pbg;
      logic [WORD_W-1:0]   sfg;
      logic [WORD_W-1:0]   sbg;
   } blit_set_t;

   localparam int SET_W = $bits(blit_set_t);

   function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_v,
                                                    input logic [WORD_W-1:0] new_v,
                                                    input logic [WORD_W/8-1:0] strb);
      logic [WORD_W-1:0] r;
      r = old_v;
      for (int i = 0; i < WORD_W/8; i++)
         if (strb[i]) r[8*i +: 8] = new_v[8*i +: 8];
      return r;
   endfunction

endpackage

// File: rtl/blq_stage.sv
module blq_stage
   import blq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [WORD_W/8-1:0] wr_strb,
   output blit_set_t         stage_q,
   output blit_set_t         snap,
   output logic              launch,
   output logic              nop_hit
);

   blit_set_t nxt;
   blit_set_t stage_d;
   logic      launch_raw;

   always_comb begin
      nxt = stage_q;
      if (wr_en) begin
         case (reg_addr_e'(wr_addr))
            RA_CMD:     nxt.cmd    = lane_merge(stage_q.cmd,    wr_data, wr_strb);
            RA_DXY:     nxt.dxy    = lane_merge(stage_q.dxy,    wr_data, wr_strb);
            RA_SXY:     nxt.sxy    = lane_merge(stage_q.sxy,    wr_data, wr_strb);
            RA_SIZE:    nxt.size   = lane_merge(stage_q.size,   wr_data, wr_strb);
            RA_SBASE:   nxt.sbase  = lane_merge(stage_q.sbase,  wr_data, wr_strb);
            RA_DBASE:   nxt.dbase  = lane_merge(stage_q.dbase,  wr_data, wr_strb);
            RA_STRIDE:  nxt.stride = lane_merge(stage_q.stride, wr_data, wr_strb);
            RA_CLIPX:   nxt.clipx  = lane_merge(stage_q.clipx,  wr_data, wr_strb);
            RA_CLIPY:   nxt.clipy  = lane_merge(stage_q.clipy,  wr_data, wr_strb);
            RA_MONO_LO: nxt.mono[WORD_W-1:0] =
                           lane_merge(stage_q.mono[WORD_W-1:0], wr_data, wr_strb);
            RA_MONO_HI: nxt.mono[2*WORD_W-1:WORD_W] =
                           lane_merge(stage_q.mono[2*WORD_W-1:WORD_W], wr_data, wr_strb);
            RA_PFG:     nxt.pfg    = lane_merge(stage_q.pfg,    wr_data, wr_strb);
            RA_PBG:     nxt.pbg    = lane_merge(stage_q.pbg,    wr_data, wr_strb);
            RA_SFG:     nxt.sfg    = lane_merge(stage_q.sfg,    wr_data, wr_strb);
            RA_SBG:     nxt.sbg    = lane_merge(stage_q.sbg,    wr_data, wr_strb);
            default:    ;
         endcase
      end
      launch_raw = wr_en &&
                   (((reg_addr_e'(wr_addr) == RA_CMD) && !nxt.cmd[AUTO_BIT]) ||
                    ((reg_addr_e'(wr_addr) == RA_DXY) && stage_q.cmd[AUTO_BIT]));
      nop_hit = launch_raw && (nxt.cmd[TYPE_LSB +: 4] == TYPE_NOP);
      launch  = launch_raw && !nop_hit;
      stage_d = nxt;
      if (nop_hit) stage_d.cmd[AUTO_BIT] = 1'b0;
   end

   assign snap = nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q      <= '0;
         stage_q.mono <= '1;
      end else begin
         stage_q <= stage_d;
      end
   end

   AST_MONO_LO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr_e'(wr_addr) == RA_MONO_LO) |=> $stable(stage_q.mono[2*WORD_W-1:WORD_W])); // R3
   AST_MONO_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr_e'(wr_addr) == RA_MONO_HI) |=> $stable(stage_q.mono[WORD_W-1:0])); // R3
   AST_NOP_CLEARS_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
      nop_hit |=> !stage_q.cmd[AUTO_BIT]); // R6

endmodule

// File: rtl/blq_fifo.sv
module blq_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop_req,
   output logic [WIDTH-1:0] rdata,
   output logic             rvld,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             ovf
);

   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             full, push_ok, pop_ok;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop_req && !empty;

   if (POW2) begin : g_wrap_nat
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         rvld   <= 1'b0;
         rdata  <= '0;
         ovf    <= 1'b0;
      end else begin
         rvld <= pop_ok;
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok) begin
            rd_ptr <= rd_nxt;
            rdata  <= mem[rd_ptr];
         end
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: ;
         endcase
         if (push && full) ovf <= 1'b1;
      end
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R11
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop_req) |=> (count == $past(count))); // R11
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf); // R11
   AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop_req) |=> (count == $past(count) + 1'b1)); // R4
   AST_VLD_FROM_POP: assert property (@(posedge clk) disable iff (!rst_n)
      rvld |-> ($past(pop_req) && $past(count) != '0)); // R7

endmodule

// File: rtl/blq_rdmux.sv
module blq_rdmux
   import blq_pkg::*;
(
   input  logic [3:0]        rd_addr,
   input  blit_set_t         stage_q,
   input  logic [WORD_W-1:0] status,
   output logic [WORD_W-1:0] rd_data
);

   always_comb begin
      case (reg_addr_e'(rd_addr))
         RA_CMD:     rd_data = stage_q.cmd;
         RA_DXY:     rd_data = stage_q.dxy;
         RA_SXY:     rd_data = stage_q.sxy;
         RA_SIZE:    rd_data = stage_q.size;
         RA_SBASE:   rd_data = stage_q.sbase;
         RA_DBASE:   rd_data = stage_q.dbase;
         RA_STRIDE:  rd_data = stage_q.stride;
         RA_CLIPX:   rd_data = stage_q.clipx;
         RA_CLIPY:   rd_data = stage_q.clipy;
         RA_MONO_LO: rd_data = stage_q.mono[WORD_W-1:0];
         RA_MONO_HI: rd_data = stage_q.mono[2*WORD_W-1:WORD_W];
         RA_PFG:     rd_data = stage_q.pfg;
         RA_PBG:     rd_data = stage_q.pbg;
         RA_SFG:     rd_data = stage_q.sfg;
         RA_SBG:     rd_data = stage_q.sbg;
         default:    rd_data = status;
      endcase
   end

endmodule

// File: rtl/blit_cmd_queue.sv
module blit_cmd_queue
   import blq_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [3:0]          wr_addr,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic [WORD_W/8-1:0] wr_strb,
   input  logic [3:0]          rd_addr,
   output logic [WORD_W-1:0]   rd_data,
   input  logic                eng_ready,
   input  logic                eng_busy,
   output logic                op_vld,
   output logic [SET_W-1:0]    op_data
);

   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int FREE_W = 5;

   if (DEPTH < 2 || DEPTH > 32) begin : g_bad_depth
      $error("blit_cmd_queue: DEPTH must lie in 2..32");
   end

   blit_set_t         stage_q, snap;
   logic              launch, nop_hit, q_empty, q_ovf;
   logic [CNT_W-1:0]  q_count;
   logic [WORD_W-1:0] status;

   blq_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_strb (wr_strb),
      .stage_q (stage_q),
      .snap    (snap),
      .launch  (launch),
      .nop_hit (nop_hit)
   );

   blq_fifo #(.WIDTH(SET_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (launch),
      .wdata   (snap),
      .pop_req (eng_ready),
      .rdata   (op_data),
      .rvld    (op_vld),
      .count   (q_count),
      .empty   (q_empty),
      .ovf     (q_ovf)
   );

   always_comb begin
      status         = '0;
      status[13]     = !eng_busy && q_empty;
      status[12:8]   = FREE_W'(DEPTH - 1) - FREE_W'(q_count);
      status[0]      = q_ovf;
   end

   blq_rdmux u_rdmux (
      .rd_addr (rd_addr),
      .stage_q (stage_q),
      .status  (status),
      .rd_data (rd_data)
   );

   AST_NOP_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (nop_hit && !eng_ready) |=> $stable(q_count)); // R6
   AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && !$past(eng_ready, 1)) |-> 1'b0); // R7

endmodule

// File: tb/blit_cmd_queue_tb_top.sv
module blit_cmd_queue_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int QD = 16;
   localparam int SW = 13*32 + 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [3:0]    wr_strb = '0;
   logic [3:0]    rd_addr = '0;
   logic [31:0]   rd_data;
   logic          eng_ready = 1'b0;
   logic          eng_busy = 1'b0;
   logic          op_vld;
   logic [SW-1:0] op_data;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [31:0] mdl [16];
   logic [SW-1:0] mq [QD];
   int head = 0;
   int mcnt = 0;
   bit movf = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   blit_cmd_queue #(.DEPTH(QD)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_strb(wr_strb), .rd_addr(rd_addr), .rd_data(rd_data),
      .eng_ready(eng_ready), .eng_busy(eng_busy), .op_vld(op_vld), .op_data(op_data)
   );

   task automatic chk(input string tag, input logic [SW-1:0] got, input logic [SW-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic logic [SW-1:0] pack_set();
      return {mdl[0], mdl[1], mdl[2], mdl[3], mdl[4], mdl[5], mdl[6], mdl[7], mdl[8],
              mdl[10], mdl[9], mdl[11], mdl[12], mdl[13], mdl[14]};
   endfunction

   function automatic logic [31:0] exp_stat();
      logic [31:0] s;
      s = '0;
      s[13] = !eng_busy && (mcnt == 0);
      s[12:8] = 5'(15 - mcnt);
      s[0] = movf;
      return s;
   endfunction

   task automatic rd(input int a, output logic [31:0] d);
      rd_addr = 4'(a);
      #1;
      d = rd_data;
   endtask

   task automatic wr(input int a, input logic [31:0] d, input logic [3:0] s);
      logic [31:0] m;
      bit go;
      if (a != 15) begin
         m = mdl[a];
         for (int i = 0; i < 4; i++) if (s[i]) m[8*i +: 8] = d[8*i +: 8];
         go = (a == 0 && !m[0]) || (a == 1 && mdl[0][0]);
         mdl[a] = m;
         if (go) begin
            if (mdl[0][30:27] == 4'hF) mdl[0][0] = 1'b0;
            else if (mcnt < QD) begin
               mq[(head + mcnt) % QD] = pack_set();
               mcnt++;
            end else movf = 1;
         end
      end
      @(negedge clk);
      wr_en = 1; wr_addr = 4'(a); wr_data = d; wr_strb = s;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic chk_stat(input string tag);
      logic [31:0] v;
      rd(15, v);
      chk(tag, SW'(v), SW'(exp_stat()));
   endtask

   task automatic pop_one(input string tag);
      @(negedge clk);
      eng_ready = 1;
      @(negedge clk);
      eng_ready = 0;
      chk({tag, " vld"}, SW'(op_vld), SW'(1'b1));
      chk({tag, " data"}, op_data, mq[head]);
      head = (head + 1) % QD;
      mcnt--;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      for (int i = 0; i < 16; i++) mdl[i] = '0;
      mdl[9] = '1; mdl[10] = '1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset values
      for (int a = 0; a < 15; a++) begin
         rd(a, v);
         chk($sformatf("R1 reset word %0d", a), SW'(v), SW'(mdl[a]));
      end
      rd(15, v);
      chk("R1 reset status", SW'(v), SW'(32'h0000_2F00));
      chk("R1 reset op_vld", SW'(op_vld), '0);

      // R2 byte-strobe sweep
      for (int s = 0; s < 16; s++) begin
         wr(13, 32'hA5C3_0F96 ^ (32'h0101_0101 * s), 4'(s));
         rd(13, v);
         chk($sformatf("R2 strobe %0h", s), SW'(v), SW'(mdl[13]));
      end

      // R3 pattern halves
      wr(9, 32'h1234_5678, 4'hF);
      rd(10, v); chk("R3 hi kept", SW'(v), SW'(32'hFFFF_FFFF));
      rd(9, v);  chk("R3 lo set", SW'(v), SW'(32'h1234_5678));
      wr(10, 32'h9ABC_DEF0, 4'hF);
      rd(9, v);  chk("R3 lo kept", SW'(v), SW'(32'h1234_5678));
      rd(10, v); chk("R3 hi set", SW'(v), SW'(32'h9ABC_DEF0));

      for (int a = 2; a < 15; a++)
         if (a != 9 && a != 10) wr(a, 32'h1100_0000 * a + 32'h0000_0A0B * a, 4'hF);

      // R4 command-word launch
      wr(0, 32'h0000_0010, 4'hF);
      chk_stat("R4 launch on cmd");
      wr(0, 32'h0000_0011, 4'hF);
      chk_stat("R4 no launch with auto set");

      // R5 auto mode
      for (int k = 0; k < 3; k++) begin
         wr(1, 32'h0040_0020 + k, 4'hF);
         chk_stat("R5 auto launch");
      end
      wr(0, 32'h0000_0020, 4'hF);
      wr(1, 32'h0077_0077, 4'hF);
      chk_stat("R5 no auto launch");

      // R6 no-op type
      wr(0, 32'h7800_0001, 4'hF);
      wr(1, 32'h0001_0001, 4'hF);
      chk_stat("R6 nop via coord");
      rd(0, v); chk("R6 auto cleared", SW'(v), SW'(32'h7800_0000));
      wr(0, 32'h7800_0000, 4'hF);
      chk_stat("R6 nop via cmd");

      // R9 writes to status ignored
      wr(15, 32'hFFFF_FFFF, 4'hF);
      chk_stat("R9 status write ignored");

      // R10 busy masks idle
      eng_busy = 1;
      chk_stat("R10 busy");

      // R9/R11 fill sweep and overflow
      while (mcnt < QD) begin
         wr(14, 32'hC000_0000 + mcnt, 4'hF);
         wr(0, 32'h0000_0004, 4'hF);
         chk_stat($sformatf("R9 fill level %0d", mcnt));
      end
      wr(14, 32'hDEAD_BEEF, 4'hF);
      wr(0, 32'h0000_0004, 4'hF);
      chk_stat("R11 overflow flagged");

      // R12 staging changes after launch
      wr(13, 32'h5555_AAAA, 4'hF);
      rd(13, v); chk("R12 read staging", SW'(v), SW'(32'h5555_AAAA));

      // R7/R8 drain in order
      while (mcnt > 0) begin
         pop_one($sformatf("R7 R8 R12 pop %0d", mcnt));
         chk_stat("R9 drain level");
      end
      @(negedge clk);
      chk("R7 vld pulse", SW'(op_vld), '0);
      eng_ready = 1;
      @(negedge clk);
      @(negedge clk);
      eng_ready = 0;
      chk("R7 empty no vld", SW'(op_vld), '0);

      chk_stat("R10 busy empty");
      eng_busy = 0;
      chk_stat("R10 idle R11 sticky");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule